// File: doc/BRIEF.md
# Comparator Event Timer with Message Interrupt

The block is a timer peripheral built around one 64-bit up-counter and one comparator channel. Software reaches it through a simple 64-bit register port. It can gate the counter, preload it (for example with a negative value so that it counts up toward the wrap), program a comparator value, and pick how a match is reported. When the running counter equals the comparator, the channel sets a sticky status bit. Software clears that bit by writing a one to it.

A match can be reported in two ways. The first is a dedicated interrupt wire, which either follows the status bit (level) or pulses for one cycle (edge). The second is a single-beat message write on a separate port. That write carries an address and a data word taken from the channel's route register.

The message port follows valid/ready rules. `msg_valid` rises with a payload and holds `msg_valid`, `msg_addr` and `msg_data` unchanged until a cycle where `msg_ready` is high. That cycle is the transfer. Back-pressure never loses the pending message. A further match that arrives while a message still waits is folded into the waiting one. Register reads return data on `bus_rdata` in the cycle after the request.

Top module: `evt_timer`

## Requirements
- R1: Offset 0x000 reads the tick period in femtoseconds (parameter `PERIOD_FS`) in bits [63:32] and zero in bits [31:0]. Writes to it are ignored.
- R2: Bit 0 of the global control register (offset 0x010) gates the counter. While it is 1, the counter (offset 0x0F0) adds one every clock. While it is 0, the counter holds its value.
- R3: A write to offset 0x0F0 loads the counter. Counting past all-ones wraps to zero.
- R4: If the counter is gated on and equals the comparator (offset 0x108) in a cycle, bit 0 of the status register (offset 0x020) reads 1 from the next cycle. This happens whether or not the interrupt enable is set.
- R5: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R6: In the channel control register (offset 0x100), bit 14 selects message delivery, bit 2 enables interrupts and bit 1 selects level (1) or edge (0). These bits are read/write. Bits 15 and 5 always read 1, bit 4 always reads 0, and writes to those three bits are ignored.
- R7: With bits 14 and 2 set, a match raises `msg_valid` in the next cycle. `msg_addr` then carries route bits [63:32] and `msg_data` carries route bits [31:0] (route register at offset 0x110). All three hold until `msg_ready` is high, and `irq_out` stays low throughout.
- R8: A match that occurs while a message is valid and not being accepted adds no second message.
- R9: With bit 2 set, bit 14 clear and bit 1 set, `irq_out` equals the status bit.
- R10: With bit 2 set and bits 14 and 1 clear, `irq_out` is high for exactly one cycle per match.
- R11: Reads of any other offset, including unaligned ones, return zero, and writes to them change nothing. Read data appears one cycle after the request.
- R12: With bit 2 clear, `irq_out` stays low and no message is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after request |
| irq_out | output | 1 | Level or edge interrupt wire |
| msg_valid | output | 1 | Message write pending |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 32 | Message data word |

## Verification
The bench drives the counter across the all-ones wrap and compares it against a reference model. A design that drops the carry or the gating would then read back a wrong count. It holds `msg_ready` low while forcing a second match. A design that queues or re-issues the message would show two transfers, and one that lets the payload drift would miss the per-clock comparison. It writes zero and ones to the status bit and to the read-only channel bits, which catches a set-on-write status or writable capability flags. It also probes reserved and unaligned offsets, where a loose decoder would alias a real register.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned OFF_CAP   = 'h000;
  localparam int unsigned OFF_GCTL  = 'h010;
  localparam int unsigned OFF_STAT  = 'h020;
  localparam int unsigned OFF_COUNT = 'h0F0;
  localparam int unsigned OFF_CHCTL = 'h100;
  localparam int unsigned OFF_CMP   = 'h108;
  localparam int unsigned OFF_ROUTE = 'h110;

  localparam int unsigned B_MSG_CAP = 15;
  localparam int unsigned B_MSG_EN  = 14;
  localparam int unsigned B_W64_CAP = 5;
  localparam int unsigned B_PER_CAP = 4;
  localparam int unsigned B_INT_EN  = 2;
  localparam int unsigned B_LEVEL   = 1;

  typedef struct packed {
    logic msg_en;
    logic int_en;
    logic level;
  } chan_ctl_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= load_val;
    else if (run)   count <= count + W'(1);
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel import evt_timer_pkg::*; #(
  parameter int unsigned W  = 64,
  parameter int unsigned MW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [W-1:0]  count,
  input  logic [W-1:0]  cmp,
  input  chan_ctl_t     ctl,
  input  logic          clr,
  input  logic [MW-1:0] route_addr,
  input  logic [MW-1:0] route_data,
  input  logic          msg_ready,
  output logic          status,
  output logic          irq,
  output logic          msg_valid,
  output logic [MW-1:0] msg_addr,
  output logic [MW-1:0] msg_data
);
  logic hit, pulse_q, fire, slot_free;

  assign hit       = run && (count == cmp);
  assign fire      = hit && ctl.int_en && ctl.msg_en;
  assign slot_free = !msg_valid || msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (hit)      status <= 1'b1;
      else if (clr) status <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (fire && slot_free) begin
      msg_valid <= 1'b1;
      msg_addr  <= route_addr;
      msg_data  <= route_data;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  assign irq = ctl.int_en && !ctl.msg_en && (ctl.level ? status : pulse_q);
endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_timer_pkg::*; #(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              irq_out,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [31:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int unsigned DW = 64;
  localparam int unsigned HW = DW / 2;

  logic          sel_cap, sel_gctl, sel_stat, sel_cnt, sel_chctl, sel_cmp, sel_route;
  logic          wr, rd;
  logic          gen_en;
  chan_ctl_t     ch_ctl;
  logic [DW-1:0] cmp_q, route_q, cnt_val, rd_mux;
  logic          cnt_wr, stat_clr, stat_q;

  always_comb begin
    sel_cap   = (bus_addr == ADDR_W'(OFF_CAP));
    sel_gctl  = (bus_addr == ADDR_W'(OFF_GCTL));
    sel_stat  = (bus_addr == ADDR_W'(OFF_STAT));
    sel_cnt   = (bus_addr == ADDR_W'(OFF_COUNT));
    sel_chctl = (bus_addr == ADDR_W'(OFF_CHCTL));
    sel_cmp   = (bus_addr == ADDR_W'(OFF_CMP));
    sel_route = (bus_addr == ADDR_W'(OFF_ROUTE));
  end

  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;
  assign cnt_wr   = wr && sel_cnt;
  assign stat_clr = wr && sel_stat && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en  <= 1'b0;
      ch_ctl  <= '0;
      cmp_q   <= '0;
      route_q <= '0;
    end else if (wr) begin
      if (sel_gctl)  gen_en  <= bus_wdata[0];
      if (sel_chctl) ch_ctl  <= '{msg_en: bus_wdata[B_MSG_EN],
                                  int_en: bus_wdata[B_INT_EN],
                                  level:  bus_wdata[B_LEVEL]};
      if (sel_cmp)   cmp_q   <= bus_wdata;
      if (sel_route) route_q <= bus_wdata;
    end
  end

  evt_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(gen_en), .load(cnt_wr),
    .load_val(bus_wdata), .count(cnt_val)
  );

  evt_channel #(.W(DW), .MW(HW)) u_ch (
    .clk(clk), .rst_n(rst_n), .run(gen_en), .count(cnt_val), .cmp(cmp_q),
    .ctl(ch_ctl), .clr(stat_clr),
    .route_addr(route_q[DW-1:HW]), .route_data(route_q[HW-1:0]),
    .msg_ready(msg_ready), .status(stat_q), .irq(irq_out),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_cap)   rd_mux = {PERIOD_FS, 32'd0};
    if (sel_gctl)  rd_mux[0] = gen_en;
    if (sel_stat)  rd_mux[0] = stat_q;
    if (sel_cnt)   rd_mux = cnt_val;
    if (sel_chctl) begin
      rd_mux[B_MSG_CAP] = 1'b1;
      rd_mux[B_W64_CAP] = 1'b1;
      rd_mux[B_PER_CAP] = 1'b0;
      rd_mux[B_MSG_EN]  = ch_ctl.msg_en;
      rd_mux[B_INT_EN]  = ch_ctl.int_en;
      rd_mux[B_LEVEL]   = ch_ctl.level;
    end
    if (sel_cmp)   rd_mux = cmp_q;
    if (sel_route) rd_mux = route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        cnt_ld,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic        status,
  input logic        ie,
  input logic        irq_out,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [31:0] msg_addr,
  input logic [31:0] msg_data
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> $stable(cnt));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_ld) |=> (cnt == $past(cnt) + 64'd1));
  // R4
  match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == cmp) |=> status);
  // R7
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq_out);
endmodule

bind evt_timer evt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(gen_en), .cnt_ld(cnt_wr), .cnt(cnt_val),
  .cmp(cmp_q), .status(stat_q), .ie(ch_ctl.int_en), .irq_out(irq_out),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam logic [31:0] PER = 32'd10_000_000;
  localparam int unsigned AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, msg_ready = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic irq_out, msg_valid;
  logic [31:0] msg_addr, msg_data;

  int checks = 0, fails = 0, accepted = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_timer #(.ADDR_W(AW), .PERIOD_FS(PER)) u_evt_timer (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // behavioural reference
  bit m_en, m_stat, m_fsb, m_ie, m_lvl, m_pulse, m_mv;
  logic [63:0] m_cnt, m_cmp, m_route, m_rd;
  logic [31:0] m_ma, m_md;

  function automatic logic [63:0] ref_read(input logic [AW-1:0] a);
    case (int'(a))
      'h000: return {PER, 32'd0};
      'h010: return {63'd0, m_en};
      'h020: return {63'd0, m_stat};
      'h0F0: return m_cnt;
      'h100: return 64'h8020 | (64'(m_fsb) << 14) | (64'(m_ie) << 2) | (64'(m_lvl) << 1);
      'h108: return m_cmp;
      'h110: return m_route;
      default: return 64'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_stat = 0; m_fsb = 0; m_ie = 0; m_lvl = 0; m_pulse = 0; m_mv = 0;
      m_cnt = 0; m_cmp = 0; m_route = 0; m_rd = 0; m_ma = 0; m_md = 0;
    end else begin
      bit hit, was_en;
      hit = m_en && (m_cnt == m_cmp);
      was_en = m_en;
      if (msg_valid && msg_ready) accepted++;
      if (bus_en && !bus_we) m_rd = ref_read(bus_addr);
      if (hit && m_ie && m_fsb && (!m_mv || msg_ready)) begin
        m_mv = 1; m_ma = m_route[63:32]; m_md = m_route[31:0];
      end else if (m_mv && msg_ready) m_mv = 0;
      m_pulse = hit;
      if (hit) m_stat = 1;
      else if (bus_en && bus_we && bus_addr == 10'h020 && bus_wdata[0]) m_stat = 0;
      if (bus_en && bus_we && bus_addr == 10'h0F0) m_cnt = bus_wdata;
      else if (was_en) m_cnt = m_cnt + 64'd1;
      if (bus_en && bus_we) begin
        case (int'(bus_addr))
          'h010: m_en = bus_wdata[0];
          'h100: begin m_fsb = bus_wdata[14]; m_ie = bus_wdata[2]; m_lvl = bus_wdata[1]; end
          'h108: m_cmp = bus_wdata;
          'h110: m_route = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    check("R9 irq_out", 64'(irq_out),
          64'(m_ie && !m_fsb && (m_lvl ? m_stat : m_pulse)));
    check("R7 msg_valid", 64'(msg_valid), 64'(m_mv));
    if (m_mv) check("R7 msg payload", {msg_addr, msg_data}, {m_ma, m_md});
    check("R11 bus_rdata", bus_rdata, m_rd);
  end

  task automatic wr(input int a, input logic [63:0] d);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a);
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v, v2;
    int hi;
    idle(3);
    rst_n = 1;
    idle(2);
    // reset state
    rd('h000, v); check("R1 caps", v, {PER, 32'd0});
    rd('h010, v); check("R2 gctl reset", v, 0);
    rd('h020, v); check("R4 status reset", v, 0);
    rd('h0F0, v); check("R3 count reset", v, 0);
    rd('h100, v); check("R6 chctl reset", v, 64'h8020);
    check("R12 irq reset", 64'(irq_out), 0);
    // gating
    idle(4);
    rd('h0F0, v); check("R2 hold while off", v, 0);
    wr('h010, 1);
    rd('h0F0, v); idle(3); rd('h0F0, v2);
    check("R2 step per clock", v2 - v, 4);
    wr('h010, 0);
    rd('h0F0, v); idle(5); rd('h0F0, v2);
    check("R2 hold after off", v2, v);
    // load and wrap
    wr('h0F0, 64'hFFFF_FFFF_FFFF_FFFD);
    rd('h0F0, v); check("R3 load", v, 64'hFFFF_FFFF_FFFF_FFFD);
    wr('h010, 1); idle(6); wr('h010, 0);
    rd('h0F0, v); check("R3 wrap", v, m_cnt); check("R3 wrapped small", 64'(v < 10), 1);
    // level interrupt
    wr('h100, 64'h6); wr('h108, 2); wr('h0F0, 0); wr('h020, 1);
    wr('h010, 1); idle(6); wr('h010, 0);
    rd('h020, v); check("R4 status set", v, 1);
    check("R9 level high", 64'(irq_out), 1);
    wr('h020, 0); rd('h020, v); check("R5 write zero", v, 1);
    wr('h020, 1); rd('h020, v); check("R5 write one clears", v, 0);
    check("R9 level low", 64'(irq_out), 0);
    // read-only channel bits
    wr('h100, 64'h30); rd('h100, v); check("R6 caps fixed", v, 64'h8020);
    wr('h100, '1);     rd('h100, v); check("R6 rw bits", v, 64'hC026);
    // interrupts disabled
    wr('h100, 0); wr('h108, 3); wr('h0F0, 0);
    wr('h010, 1); idle(6); wr('h010, 0);
    rd('h020, v); check("R4 status without enable", v, 1);
    check("R12 no irq", 64'(irq_out), 0);
    check("R12 no msg", 64'(msg_valid), 0);
    wr('h020, 1);
    // message delivery with back-pressure and merge
    accepted = 0;
    wr('h110, 64'hFEE0_1000_0000_4031);
    wr('h100, 64'h4006); wr('h108, 20); wr('h0F0, 15);
    wr('h010, 1); idle(8);
    check("R7 msg raised", 64'(msg_valid), 1);
    check("R7 msg payload", {msg_addr, msg_data}, 64'hFEE0_1000_0000_4031);
    check("R7 irq low", 64'(irq_out), 0);
    wr('h0F0, 18); idle(4); wr('h010, 0);
    check("R8 still one pending", 64'(msg_valid), 1);
    msg_ready = 1; idle(3); msg_ready = 0;
    check("R8 single transfer", 64'(accepted), 1);
    check("R7 released", 64'(msg_valid), 0);
    wr('h020, 1);
    // edge interrupt
    wr('h100, 64'h4); wr('h108, 4); wr('h0F0, 0);
    wr('h010, 1);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq_out) hi++;
    end
    wr('h010, 0);
    check("R10 one pulse", 64'(hi), 1);
    // reserved offsets
    wr('h018, '1); rd('h018, v); check("R11 reserved read", v, 0);
    wr('h000, '1); rd('h000, v); check("R1 caps unwritable", v, {PER, 32'd0});
    rd('h0F8, v);  check("R11 reserved gap", v, 0);
    rd('h011, v);  check("R11 unaligned", v, 0);
    rd('h108, v);  check("R11 cmp intact", v, 4);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule